// File: doc/BRIEF.md
# Instruction-set mode transition unit

This block carries out the jump that leaves the legacy 32-bit instruction set and enters the native 64-bit one. A decoder presents one instruction per cycle on `ins_valid`, together with its two opcode bytes, the ModRM reg field, the register or memory operand, the displacement, the code-segment base, the privilege level, the operand size and the address of the following instruction. One cycle later the block reports its result. On success that result is a switch strobe with the 64-bit target, a link write to general register 1 and a status-clear pulse. On failure it is exactly one fault strobe.

A successful switch sets a sticky native-mode indicator. While that indicator is set, the legacy decode no longer applies and further issues are ignored until reset. Branch debugging requested at issue adds a debug trap one cycle after the switch strobe. At that point the link write and the mode change have both landed. The block never requests a fence or serialization, and it leaves the privilege level alone.

Top module: `isa_switch_unit`

## Requirements
- R1: The block recognises an issue only for opcode bytes 0x0F,0x00 with ModRM reg field 6 (indirect form, target from `rm_val`) or 0x0F,0xB8 (absolute form, target from `disp_val`). Any other byte pair or reg value produces no strobe of any kind.
- R2: With `op32`=0 the selected operand is zero-extended from its low 16 bits. With `op32`=1 all 32 bits are used.
- R3: One cycle after a successful issue, `sw_strobe` is high for exactly one cycle. In that cycle `tgt_addr[31:4]` holds bits 31:4 of the 32-bit wrapping sum of operand and `cs_base`, and `tgt_addr[63:32]` and `tgt_addr[3:0]` are zero.
- R4: In the same cycle as `sw_strobe`, `gr1_we` is high and `gr1_data` holds `next_ip` zero-extended to 64 bits.
- R5: With `env_present`=0, a recognised issue raises `flt_term` when `cpl`=0, or `flt_illegal` when `cpl` is 1 to 3. It commits nothing.
- R6: With the environment present and `isd_bit`=1, a recognised issue raises `flt_disabled`. It commits nothing.
- R7: With the environment present, `isd_bit`=0 and `fp_pend`=1, a recognised issue raises `flt_fp`. It commits nothing.
- R8: At most one fault strobe is high in any cycle. The priority is environment absent, then disable bit, then pending floating-point exception.
- R9: A successful issue pulses `flag_clr` together with `sw_strobe` and sets `native_mode`. `native_mode` then stays set until reset.
- R10: If `brdbg_en` was high at a successful issue, `dbg_trap` pulses exactly one cycle after `sw_strobe`. Otherwise it stays low.
- R11: While `native_mode` is set, issues are ignored: no switch, write, fault or flag pulse results.
- R12: During reset every output is low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction issued this cycle |
| opc_b0 | input | 8 | First opcode byte |
| opc_b1 | input | 8 | Second opcode byte |
| modrm_reg | input | 3 | ModRM reg field |
| rm_val | input | 32 | Register or memory operand (indirect form) |
| disp_val | input | 32 | Unsigned displacement (absolute form) |
| cs_base | input | 32 | Code-segment base |
| cpl | input | 2 | Current privilege level |
| op32 | input | 1 | 1 = 32-bit operand size, 0 = 16-bit |
| next_ip | input | 32 | Address of next sequential legacy instruction |
| env_present | input | 1 | Native-mode environment available |
| isd_bit | input | 1 | Instruction-set transition disabled |
| fp_pend | input | 1 | Unmasked floating-point exception pending |
| brdbg_en | input | 1 | Branch debugging enabled |
| sw_strobe | output | 1 | One-cycle mode-switch pulse |
| tgt_addr | output | 64 | Native target address |
| gr1_we | output | 1 | Write enable for general register 1 |
| gr1_data | output | 64 | Link value for general register 1 |
| flt_illegal | output | 1 | Illegal-opcode fault |
| flt_term | output | 1 | Legacy environment termination |
| flt_disabled | output | 1 | Disabled transition fault |
| flt_fp | output | 1 | Floating-point fault |
| flag_clr | output | 1 | Clear resume and instruction-debug flags |
| native_mode | output | 1 | Native instruction set active |
| dbg_trap | output | 1 | Debug trap after completion |

## Verification
Each issue's switch strobe, target, link write, flag pulse and fault strobes are due on the first rising edge after the issue. The debug trap is due one edge later, and `native_mode` changes on the same edge as the switch strobe. The bench drives inputs at the falling edge. At the next falling edge its reference model evaluates the issue that was just clocked in and compares every output. It carries the trap forward by one cycle in a model variable. Target and link values are compared only in cycles where a switch is expected.

// File: rtl/isa_switch_unit.sv
module isa_switch_unit #(
  parameter int AW = 64,
  parameter int VW = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  input  logic [7:0]    opc_b0,
  input  logic [7:0]    opc_b1,
  input  logic [2:0]    modrm_reg,
  input  logic [VW-1:0] rm_val,
  input  logic [VW-1:0] disp_val,
  input  logic [VW-1:0] cs_base,
  input  logic [1:0]    cpl,
  input  logic          op32,
  input  logic [VW-1:0] next_ip,
  input  logic          env_present,
  input  logic          isd_bit,
  input  logic          fp_pend,
  input  logic          brdbg_en,
  output logic          sw_strobe,
  output logic [AW-1:0] tgt_addr,
  output logic          gr1_we,
  output logic [AW-1:0] gr1_data,
  output logic          flt_illegal,
  output logic          flt_term,
  output logic          flt_disabled,
  output logic          flt_fp,
  output logic          flag_clr,
  output logic          native_mode,
  output logic          dbg_trap
);
  localparam int HI = AW - VW;
  localparam int LO16 = VW - 16;

  logic          is_ind, is_abs, fire, ok, f_env, f_dis, f_fp;
  logic [VW-1:0] raw, src, sum;
  logic          trap_pend;

  assign is_ind = (opc_b0 == 8'h0F) && (opc_b1 == 8'h00) && (modrm_reg == 3'd6);
  assign is_abs = (opc_b0 == 8'h0F) && (opc_b1 == 8'hB8);
  assign fire   = ins_valid && !native_mode && (is_ind || is_abs);

  assign raw = is_ind ? rm_val : disp_val;
  assign src = op32 ? raw : {{LO16{1'b0}}, raw[15:0]};
  assign sum = src + cs_base;

  assign f_env = !env_present;
  assign f_dis = env_present && isd_bit;
  assign f_fp  = env_present && !isd_bit && fp_pend;
  assign ok    = !f_env && !f_dis && !f_fp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_strobe    <= 1'b0;
      tgt_addr     <= '0;
      gr1_we       <= 1'b0;
      gr1_data     <= '0;
      flt_illegal  <= 1'b0;
      flt_term     <= 1'b0;
      flt_disabled <= 1'b0;
      flt_fp       <= 1'b0;
      flag_clr     <= 1'b0;
      native_mode  <= 1'b0;
      trap_pend    <= 1'b0;
      dbg_trap     <= 1'b0;
    end else begin
      sw_strobe    <= fire && ok;
      gr1_we       <= fire && ok;
      flag_clr     <= fire && ok;
      flt_illegal  <= fire && f_env && (cpl != 2'd0);
      flt_term     <= fire && f_env && (cpl == 2'd0);
      flt_disabled <= fire && f_dis;
      flt_fp       <= fire && f_fp;
      trap_pend    <= fire && ok && brdbg_en;
      dbg_trap     <= trap_pend;
      if (fire && ok) begin
        native_mode <= 1'b1;
        tgt_addr    <= {{HI{1'b0}}, sum[VW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        gr1_data    <= {{HI{1'b0}}, next_ip};
      end
    end
  end
endmodule

// File: rtl/isa_switch_chk.sv
module isa_switch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sw_strobe,
  input logic [63:0] tgt_addr,
  input logic        gr1_we,
  input logic        flt_illegal,
  input logic        flt_term,
  input logic        flt_disabled,
  input logic        flt_fp,
  input logic        flag_clr,
  input logic        native_mode,
  input logic        dbg_trap
);
  logic any_flt;
  assign any_flt = flt_illegal | flt_term | flt_disabled | flt_fp;

  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flt_illegal, flt_term, flt_disabled, flt_fp})); // R8
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_strobe |=> !sw_strobe); // R3
  AST_TGT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_strobe |-> (tgt_addr[63:32] == 32'd0 && tgt_addr[3:0] == 4'd0)); // R3
  AST_FAULT_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    any_flt |-> (!sw_strobe && !gr1_we && !flag_clr)); // R5
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    native_mode |=> native_mode); // R9
  AST_SWITCH_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_strobe |-> native_mode); // R9
  AST_TRAP_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_trap |-> $past(sw_strobe)); // R10
  AST_NATIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(native_mode) |-> (!sw_strobe && !any_flt && !flag_clr)); // R11
endmodule

bind isa_switch_unit isa_switch_chk u_chk (.*);

// File: tb/tb_isa_switch_unit.sv
module tb_isa_switch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic [7:0] opc_b0 = '0, opc_b1 = '0;
  logic [2:0] modrm_reg = '0;
  logic [31:0] rm_val = '0, disp_val = '0, cs_base = '0, next_ip = '0;
  logic [1:0] cpl = '0;
  logic op32 = 1'b0, env_present = 1'b0, isd_bit = 1'b0, fp_pend = 1'b0, brdbg_en = 1'b0;
  logic sw_strobe, gr1_we, flt_illegal, flt_term, flt_disabled, flt_fp, flag_clr, native_mode, dbg_trap;
  logic [63:0] tgt_addr, gr1_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_switch_unit dut (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  bit m_native = 0, m_trap = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // compare at falling edge against the issue clocked in at the previous rising edge
  task automatic cyc();
    bit hit_i, hit_a, fire, fenv, fdis, ffp, ok;
    logic [31:0] raw, src, sum;
    string stag;
    @(negedge clk);
    if (!rst_n) begin
      chk("R12 strobe", {63'd0, sw_strobe}, 64'd0);
      chk("R12 faults", {60'd0, flt_illegal, flt_term, flt_disabled, flt_fp}, 64'd0);
      chk("R12 mode", {61'd0, native_mode, dbg_trap, flag_clr}, 64'd0);
      chk("R12 tgt", tgt_addr, 64'd0);
      chk("R12 gr1", gr1_data ^ {63'd0, gr1_we}, 64'd0);
      m_native = 0; m_trap = 0;
      return;
    end
    hit_i = opc_b0 == 8'h0F && opc_b1 == 8'h00 && modrm_reg == 3'd6;
    hit_a = opc_b0 == 8'h0F && opc_b1 == 8'hB8;
    fire  = ins_valid && !m_native && (hit_i || hit_a);
    fenv  = !env_present;
    fdis  = !fenv && isd_bit;
    ffp   = !fenv && !isd_bit && fp_pend;
    ok    = !fenv && !fdis && !ffp;
    raw   = hit_i ? rm_val : disp_val;
    src   = op32 ? raw : (raw & 32'h0000FFFF);
    sum   = src + cs_base;
    stag  = m_native ? "R11 strobe" : (!(hit_i || hit_a) ? "R1 strobe" : "R3 strobe");
    chk(stag, {63'd0, sw_strobe}, {63'd0, fire && ok});
    chk("R4 gr1_we", {63'd0, gr1_we}, {63'd0, fire && ok});
    chk("R9 flag_clr", {63'd0, flag_clr}, {63'd0, fire && ok});
    if (fire && ok) begin
      chk(op32 ? "R3 target" : "R2 target", tgt_addr, {32'd0, sum & 32'hFFFFFFF0});
      chk("R4 gr1_data", gr1_data, {32'd0, next_ip});
    end
    chk("R5 illegal", {63'd0, flt_illegal}, {63'd0, fire && fenv && cpl != 0});
    chk("R5 term", {63'd0, flt_term}, {63'd0, fire && fenv && cpl == 0});
    chk("R6 disabled", {63'd0, flt_disabled}, {63'd0, fire && fdis});
    chk("R7 fp", {63'd0, flt_fp}, {63'd0, fire && ffp});
    chk("R8 onehot", {63'd0, 1'(((flt_illegal + flt_term + flt_disabled + flt_fp) <= 1))}, 64'd1);
    chk("R10 trap", {63'd0, dbg_trap}, {63'd0, m_trap});
    m_trap = fire && ok && brdbg_en;
    if (fire && ok) m_native = 1;
    chk("R9 mode", {63'd0, native_mode}, {63'd0, m_native});
  endtask

  task automatic issue(input logic [7:0] b0, b1, input logic [2:0] rg, input logic [31:0] rm, dp, cs, nip,
                       input logic [1:0] pl, input logic o32, env, isd, fp, bd);
    ins_valid = 1; opc_b0 = b0; opc_b1 = b1; modrm_reg = rg; rm_val = rm; disp_val = dp;
    cs_base = cs; next_ip = nip; cpl = pl; op32 = o32; env_present = env; isd_bit = isd;
    fp_pend = fp; brdbg_en = bd;
    cyc();
    ins_valid = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; ins_valid = 0;
    cyc(); cyc();
    rst_n = 1;
  endtask

  initial begin
    do_reset();
    // directed: faults in priority order, then wrap and 16-bit extension
    issue(8'h0F, 8'hB8, 3'd0, 0, 32'h1234, 0, 32'h100, 2'd0, 1, 0, 1, 1, 0); cyc();
    issue(8'h0F, 8'hB8, 3'd0, 0, 32'h1234, 0, 32'h100, 2'd3, 1, 0, 1, 1, 0); cyc();
    issue(8'h0F, 8'h00, 3'd6, 32'h5, 0, 0, 32'h100, 2'd1, 1, 1, 1, 1, 0); cyc();
    issue(8'h0F, 8'h00, 3'd6, 32'h5, 0, 0, 32'h100, 2'd1, 1, 1, 0, 1, 0); cyc();
    issue(8'h0F, 8'h00, 3'd5, 32'h5, 0, 0, 32'h100, 2'd1, 1, 1, 0, 0, 0); cyc();
    issue(8'h0F, 8'h00, 3'd6, 32'hDEAD_BEEF, 0, 32'h0001_0008, 32'h4444, 2'd2, 0, 1, 0, 0, 1);
    cyc(); cyc();
    issue(8'h0F, 8'hB8, 3'd0, 0, 32'h10, 0, 32'h0, 2'd0, 1, 1, 0, 0, 0); cyc();
    do_reset();
    issue(8'h0F, 8'hB8, 3'd0, 0, 32'hFFFF_FFF8, 32'h30, 32'h9, 2'd0, 1, 1, 0, 0, 0); cyc();
    // random episodes
    for (int ep = 0; ep < 400; ep++) begin
      do_reset();
      for (int k = 0; k < 12; k++) begin
        int sel;
        logic [7:0] b1;
        logic [2:0] rg;
        sel = $urandom_range(0, 9);
        b1 = (sel < 4) ? 8'h00 : (sel < 8) ? 8'hB8 : 8'($urandom);
        rg = (sel < 3) ? 3'd6 : 3'($urandom);
        issue((sel == 9) ? 8'($urandom) : 8'h0F, b1, rg, $urandom, $urandom, $urandom, $urandom,
              2'($urandom), 1'($urandom), ($urandom_range(0, 9) != 0), ($urandom_range(0, 6) == 0),
              ($urandom_range(0, 6) == 0), 1'($urandom));
        if ($urandom_range(0, 2) == 0) cyc();
      end
      cyc();
    end
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule